// File: doc/BRIEF.md
# Interleaved Bank Block Fill Controller

This controller sits on the memory side of a cache and serves one block fill of four words. A requester presents a block address while the controller is idle. The controller then drives that address to every bank at the same time and waits out the shared bank access time. After that it hands the words back one after another over a single shared bus, with one fixed-length transfer slot per word. Because all banks access in parallel and only the transfers are serialised, a fill costs the address time, plus one access time, plus four slot times. With the default timing that is 4 + 24 + 4×4 = 44 cycles. A fill where every word paid the full 32-cycle round trip would cost 128 cycles.

A mode input chooses how the global word number k = block×4 + word is placed across the banks. Sequential placement puts the word in bank k mod B at in-bank offset k div B. Modulo placement uses bank k mod B and offset k mod D, where B is the bank count and D is the bank depth. With an odd bank count such as 3 and a power-of-two depth, the modulo placement is conflict-free by the remainder theorem. For example, word 17 lands in bank 2 at offset 1.

The controller moves through five states:
- `S_IDLE`: waits for a request; `req_valid` accepts one.
- `S_SEND`: the address phase, which lasts `ADDR_CYC` cycles and then goes to `S_WAIT`.
- `S_WAIT`: the access phase, which lasts `ACCESS_CYC` cycles and then goes to `S_XFER`.
- `S_XFER`: carries `WORDS` slots of `XFER_CYC` cycles each, then goes to `S_DONE`.
- `S_DONE`: lasts one cycle and then returns to `S_IDLE`.

Top module: `ilv_block_fill`

## Requirements
- R1: During and right after reset, `busy`, `addr_phase`, `word_valid` and `done` are 0 and `fill_cycles` is 0.
- R2: A request is taken only in `S_IDLE`. While a fill is under way, a request has no effect: the words returned and the cycle count belong to the first request.
- R3: Counting the accepting clock edge as edge 0, `word_valid` is high for exactly one cycle after edges 31, 35, 39 and 43 and low otherwise. That is, word i becomes valid after edge `ADDR_CYC + ACCESS_CYC + (i+1)×XFER_CYC − 1`.
- R4: Words come out in ascending order: `word_idx` is 0, 1, 2, 3 on the four successive `word_valid` cycles.
- R5: With `req_mode` = 0 (sequential), word i of block b reports `word_bank` = (4b+i) mod 3 and `word_off` = (4b+i) div 3.
- R6: With `req_mode` = 1 (modulo), word i of block b reports `word_bank` = (4b+i) mod 3 and `word_off` = (4b+i) mod 8. For example, block 4, word 1 gives bank 2, offset 1.
- R7: `done` is a single-cycle pulse after edge 44. `busy` is high after edges 0 through 44 and low after edge 45.
- R8: `fill_cycles` is cleared at the accepting edge and equals n after edge n up to 44. It holds 44 from the `done` cycle until the next accepted request.
- R9: The block address and mode are captured at acceptance. Changing `req_blk` or `req_mode` during a fill does not change the returned locations.
- R10: `addr_phase` is high after edges 0 through 3 only, and never together with `word_valid` or `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fill request, taken only when idle |
| req_blk | input | 3 | Block address (valid blocks 0 to 5) |
| req_mode | input | 1 | Placement: 0 sequential, 1 modulo |
| busy | output | 1 | A fill is in progress |
| addr_phase | output | 1 | The address is being driven to all banks |
| word_valid | output | 1 | A word is on the shared bus this cycle |
| word_idx | output | 2 | Word number within the block |
| word_bank | output | 2 | Bank that supplied the word |
| word_off | output | 3 | Offset of the word inside its bank |
| done | output | 1 | One-cycle pulse once the fill is complete |
| fill_cycles | output | 6 | Cycles spent on the latest fill |

## Verification
The bench builds the block with its default parameters: three banks of eight words, four-word blocks, and a 4/24/4 phase timing, so a correct fill ends exactly at 44 cycles. With three banks, the modulo placement reaches its worked case of word 17. The sequential and modulo mappings also diverge at the highest legal block, which drives the offsets up to the top of the bank. Requests and mode flips issued in the middle of a fill, and an idle stretch after `done`, bring the latching and count-hold behaviour within reach.

// File: rtl/fill_pkg.sv
package fill_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_SEND = 3'd1,
        S_WAIT = 3'd2,
        S_XFER = 3'd3,
        S_DONE = 3'd4
    } fill_state_e;

    typedef enum logic {
        MAP_SEQ = 1'b0,
        MAP_MOD = 1'b1
    } map_mode_e;

endpackage

// File: rtl/fill_counter.sv
module fill_counter #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (en) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/fill_bank_map.sv
module fill_bank_map import fill_pkg::*; #(
    parameter int unsigned NUM_BANKS  = 3,
    parameter int unsigned BANK_DEPTH = 8,
    parameter int unsigned WORDS      = 4,
    parameter int unsigned BLK_W      = 3,
    parameter int unsigned IDX_W      = 2,
    parameter int unsigned BANK_W     = 2,
    parameter int unsigned OFF_W      = 3
) (
    input  logic [BLK_W-1:0]                  blk,
    input  map_mode_e                         mode,
    output logic [WORDS-1:0][BANK_W-1:0]      bank_tab,
    output logic [WORDS-1:0][OFF_W-1:0]       off_tab
);

    localparam int unsigned K_W = BLK_W + IDX_W;

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
        logic [K_W-1:0] k_loc;
        int unsigned    k_int;
        int unsigned    off_seq;
        int unsigned    off_mod;

        assign k_loc   = {blk, IDX_W'(gi)};
        assign k_int   = 32'(k_loc);
        assign off_seq = k_int / NUM_BANKS;
        assign off_mod = k_int % BANK_DEPTH;

        assign bank_tab[gi] = BANK_W'(k_int % NUM_BANKS);
        assign off_tab[gi]  = (mode == MAP_MOD) ? OFF_W'(off_mod) : OFF_W'(off_seq);
    end

endmodule

// File: rtl/ilv_block_fill.sv
module ilv_block_fill import fill_pkg::*; #(
    parameter int unsigned NUM_BANKS  = 3,
    parameter int unsigned BANK_DEPTH = 8,
    parameter int unsigned WORDS      = 4,
    parameter int unsigned ADDR_CYC   = 4,
    parameter int unsigned ACCESS_CYC = 24,
    parameter int unsigned XFER_CYC   = 4,
    localparam int unsigned WADDR_W = $clog2(NUM_BANKS * BANK_DEPTH),
    localparam int unsigned IDX_W   = $clog2(WORDS),
    localparam int unsigned BLK_W   = WADDR_W - IDX_W,
    localparam int unsigned BANK_W  = $clog2(NUM_BANKS),
    localparam int unsigned OFF_W   = $clog2(BANK_DEPTH),
    localparam int unsigned TOTAL   = ADDR_CYC + ACCESS_CYC + WORDS * XFER_CYC,
    localparam int unsigned CYC_W   = $clog2(TOTAL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BLK_W-1:0]  req_blk,
    input  logic              req_mode,
    output logic              busy,
    output logic              addr_phase,
    output logic              word_valid,
    output logic [IDX_W-1:0]  word_idx,
    output logic [BANK_W-1:0] word_bank,
    output logic [OFF_W-1:0]  word_off,
    output logic              done,
    output logic [CYC_W-1:0]  fill_cycles
);

    localparam int unsigned XFER_LEN = WORDS * XFER_CYC;
    localparam int unsigned PH_MAX0  = (ADDR_CYC > ACCESS_CYC) ? ADDR_CYC : ACCESS_CYC;
    localparam int unsigned PH_MAX   = (PH_MAX0 > XFER_LEN) ? PH_MAX0 : XFER_LEN;
    localparam int unsigned PH_W     = $clog2(PH_MAX + 1);

    fill_state_e st_q, st_d;
    logic [BLK_W-1:0] blk_q;
    map_mode_e        mode_q;
    logic             accept;
    logic [PH_W-1:0]  ph;
    logic             ph_clr;
    logic             cyc_en;
    logic [WORDS-1:0][BANK_W-1:0] bank_tab;
    logic [WORDS-1:0][OFF_W-1:0]  off_tab;
    int unsigned      slot;
    int unsigned      beat;

    assign accept = (st_q == S_IDLE) && req_valid;

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q  <= '0;
            mode_q <= MAP_SEQ;
        end else if (accept) begin
            blk_q  <= req_blk;
            mode_q <= map_mode_e'(req_mode);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (accept) st_d = S_SEND;
            S_SEND: if (ph == PH_W'(ADDR_CYC - 1)) st_d = S_WAIT;
            S_WAIT: if (ph == PH_W'(ACCESS_CYC - 1)) st_d = S_XFER;
            S_XFER: if (ph == PH_W'(XFER_LEN - 1)) st_d = S_DONE;
            S_DONE: st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    assign ph_clr = (st_d != st_q);
    assign cyc_en = (st_q == S_SEND) || (st_q == S_WAIT) || (st_q == S_XFER);

    fill_counter #(.W(PH_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ph_clr),
        .en    (1'b1),
        .count (ph)
    );

    fill_counter #(.W(CYC_W)) u_cycles (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (cyc_en),
        .count (fill_cycles)
    );

    fill_bank_map #(
        .NUM_BANKS  (NUM_BANKS),
        .BANK_DEPTH (BANK_DEPTH),
        .WORDS      (WORDS),
        .BLK_W      (BLK_W),
        .IDX_W      (IDX_W),
        .BANK_W     (BANK_W),
        .OFF_W      (OFF_W)
    ) u_map (
        .blk      (blk_q),
        .mode     (mode_q),
        .bank_tab (bank_tab),
        .off_tab  (off_tab)
    );

    assign slot = 32'(ph) % XFER_CYC;
    assign beat = 32'(ph) / XFER_CYC;

    // outputs
    always_comb begin
        busy       = 1'b0;
        addr_phase = 1'b0;
        word_valid = 1'b0;
        word_idx   = '0;
        word_bank  = '0;
        word_off   = '0;
        done       = 1'b0;
        unique case (st_q)
            S_IDLE: ;
            S_SEND: begin
                busy       = 1'b1;
                addr_phase = 1'b1;
            end
            S_WAIT: busy = 1'b1;
            S_XFER: begin
                busy = 1'b1;
                if (slot == XFER_CYC - 1 && beat < WORDS) begin
                    word_valid = 1'b1;
                    word_idx   = IDX_W'(beat);
                    word_bank  = bank_tab[beat];
                    word_off   = off_tab[beat];
                end
            end
            S_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    beat_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R8
    fill_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fill_cycles == CYC_W'(TOTAL)));

    // R10
    addr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |-> (!word_valid && !done));

    // R2
    fresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> (fill_cycles == '0));

    // R5
    bank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (32'(word_bank) < NUM_BANKS));

endmodule

// File: tb/test_ilv_block_fill.sv
module test_ilv_block_fill;

    localparam int NB = 3;
    localparam int DEPTH = 8;
    localparam int LAST_EDGE = 44;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic [2:0] req_blk;
    logic       req_mode;
    logic       busy, addr_phase, word_valid, done;
    logic [1:0] word_idx, word_bank;
    logic [2:0] word_off;
    logic [5:0] fill_cycles;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    ilv_block_fill i_ilv_block_fill (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_blk     (req_blk),
        .req_mode    (req_mode),
        .busy        (busy),
        .addr_phase  (addr_phase),
        .word_valid  (word_valid),
        .word_idx    (word_idx),
        .word_bank   (word_bank),
        .word_off    (word_off),
        .done        (done),
        .fill_cycles (fill_cycles)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        // R1
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(addr_phase == 1'b0, "R1 addr_phase", int'(addr_phase), 0);
        chk(word_valid == 1'b0, "R1 word_valid", int'(word_valid), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(fill_cycles == 6'd0, "R1 fill_cycles", int'(fill_cycles), 0);
    endtask

    task automatic t_fill(input int blk, input bit mode, input bit disturb);
        int k, eb, eo, ewv, ebusy, eaddr, edone, efill, widx;
        string rmap;
        rmap = mode ? "R6" : "R5";
        @(negedge clk);
        req_valid = 1'b1;
        req_blk   = 3'(blk);
        req_mode  = mode;
        @(posedge clk);
        @(negedge clk);
        if (disturb) begin
            req_blk  = 3'(blk ^ 3);
            req_mode = ~mode;
        end else begin
            req_valid = 1'b0;
        end
        // R8: cleared at the accepting edge
        chk(fill_cycles == 6'd0, "R8 clear on accept", int'(fill_cycles), 0);
        chk(addr_phase == 1'b1, "R10 addr after edge 0", int'(addr_phase), 1);
        for (int n = 1; n <= LAST_EDGE + 1; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n == 40) req_valid = 1'b0;
            ebusy = (n <= LAST_EDGE) ? 1 : 0;
            eaddr = (n <= 3) ? 1 : 0;
            edone = (n == LAST_EDGE) ? 1 : 0;
            ewv   = (n >= 31 && n <= 43 && ((n - 31) % 4) == 0) ? 1 : 0;
            efill = (n <= LAST_EDGE) ? n : LAST_EDGE;
            chk(int'(busy) == ebusy, "R7 busy", int'(busy), ebusy);
            chk(int'(addr_phase) == eaddr, "R10 addr_phase", int'(addr_phase), eaddr);
            chk(int'(done) == edone, "R7 done", int'(done), edone);
            chk(int'(word_valid) == ewv, "R3 word_valid", int'(word_valid), ewv);
            chk(int'(fill_cycles) == efill, disturb ? "R2 fill_cycles" : "R8 fill_cycles",
                int'(fill_cycles), efill);
            if (ewv == 1 && word_valid) begin
                widx = (n - 31) / 4;
                k  = blk * 4 + widx;
                eb = k % NB;
                eo = mode ? (k % DEPTH) : (k / NB);
                chk(int'(word_idx) == widx, "R4 word_idx", int'(word_idx), widx);
                chk(int'(word_bank) == eb, disturb ? "R9 bank" : {rmap, " bank"},
                    int'(word_bank), eb);
                chk(int'(word_off) == eo, disturb ? "R9 offset" : {rmap, " offset"},
                    int'(word_off), eo);
            end
        end
        req_valid = 1'b0;
    endtask

    task automatic t_hold();
        repeat (10) @(negedge clk);
        // R8 holds after done
        chk(fill_cycles == 6'd44, "R8 hold", int'(fill_cycles), 44);
        chk(busy == 1'b0, "R7 idle after fill", int'(busy), 0);
    endtask

    initial begin
        #(8 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_blk   = '0;
        req_mode  = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill(0, 1'b0, 1'b0);
        t_hold();
        t_fill(4, 1'b1, 1'b0);
        t_fill(5, 1'b0, 1'b0);
        t_fill(5, 1'b1, 1'b0);
        t_fill(2, 1'b0, 1'b1);
        t_hold();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule